// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache-Line Coherency Controller

This block keeps the coherency state of a small direct-mapped cache that shares a snooping bus with other caching agents. Each line carries a tag, a data word and one of four states: Modified, Exclusive, Shared or Invalid. Local processor loads and stores arrive through a valid/ready handshake. A request that needs the bus raises a request line and waits for the grant. Transactions that other agents place on the bus come in on a snoop port. The block answers them with a "held here" indication and, for a dirty line, with the line's data.

Every bus transaction finishes in the cycle its grant is seen. The "held here" wire from the other caches and the fill data are sampled in that same cycle, so only one transaction is ever outstanding. A request that meets a dirty victim first writes the victim back. It then issues the fill, or it issues an ownership request. A snoop cycle takes priority over the local side, and the local side stalls for that cycle.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid (states encode I=00, S=01, E=10, M=11). No snoop reports a hit, and the first access to any address needs the bus.
- R2: A local store to a line held Exclusive finishes in the same cycle with no bus request, and the line becomes Modified.
- R3: A snooped read (command 00) or read-for-ownership (command 01) that hits a Modified line raises `snp_supply` in that cycle and drives the line's data on `snp_data`. After a read the line ends Shared, and after a read-for-ownership it ends Invalid.
- R4: A local store that hits a Shared line issues an invalidate (command 10) and then holds the line Modified. A snooped invalidate or read-for-ownership that hits a Shared or Exclusive line makes it Invalid.
- R5: A local load miss issues a read (command 00). The line fills with `bus_rdata` in Shared state if `bus_shared_in` is high at the grant, and in Exclusive state otherwise. The fill data is returned on `cpu_rdata` in the grant cycle.
- R6: A local store miss issues a read-for-ownership (command 01). After it the line is Modified and holds the store data.
- R7: A snooped read that hits a valid line raises `snp_shared`, and an Exclusive line then drops to Shared. Snoops that miss leave every line unchanged.
- R8: A miss whose victim line is Modified first issues a writeback (command 11) carrying the victim's address and data, without completing the processor request. A Shared or Exclusive victim is replaced with no writeback.
- R9: `cpu_ready` rises only on a hit that needs no bus, or at the grant of the final transaction. While `snp_valid` is high, neither `cpu_ready` nor `bus_req` is asserted.
- R10: A local load that hits a valid line returns the stored data in the same cycle with no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Processor request completes this cycle |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | TAG_W+IDX_W | Request address, index in the low bits |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ready |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | 00 read, 01 read-for-ownership, 10 invalidate, 11 writeback |
| bus_addr | output | TAG_W+IDX_W | Transaction address |
| bus_wdata | output | DATA_W | Writeback data |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_shared_in | input | 1 | Another cache holds the line (sampled at grant) |
| bus_rdata | input | DATA_W | Fill data (sampled at grant) |
| snp_valid | input | 1 | Snooped transaction from another agent |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | TAG_W+IDX_W | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped line (reads) |
| snp_supply | output | 1 | This cache supplies the dirty data |
| snp_data | output | DATA_W | Supplied data |

## Verification
The assertions take the bus environment as given. The grant is only seen while a request is raised, and it never coincides with a snoop. A snooped invalidate never targets a line that this cache holds Exclusive or Modified. A processor request stays stable until it is accepted. The stimulus keeps within these rules. It drives the grant only after it has observed `bus_req`, and it runs snoops only while no request is pending. It turns a random invalidate snoop into a read-for-ownership when its own model says that the line is owned here. It holds every request until the cycle in which `cpu_ready` is expected.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_e;

  typedef enum logic [1:0] {
    CMD_RD  = 2'b00,
    CMD_RDX = 2'b01,
    CMD_UPG = 2'b10,
    CMD_WB  = 2'b11
  } bus_cmd_e;

  // state a line takes when another agent's transaction hits it
  function automatic line_st_e snoop_next(line_st_e cur, bus_cmd_e cmd);
    case (cmd)
      CMD_RD:           return (cur == ST_I) ? ST_I : ST_S;
      CMD_RDX, CMD_UPG: return ST_I;
      default:          return cur;
    endcase
  endfunction

  function automatic logic snoop_supplies(line_st_e cur, bus_cmd_e cmd);
    return (cur == ST_M) && ((cmd == CMD_RD) || (cmd == CMD_RDX));
  endfunction

  function automatic line_st_e fill_state(logic others_hold);
    return others_hold ? ST_S : ST_E;
  endfunction

  // request completes locally without the bus
  function automatic logic local_done(logic hit, line_st_e cur, logic wr);
    return hit && (!wr || (cur == ST_E) || (cur == ST_M));
  endfunction

  // bus command for a request that cannot complete locally
  function automatic bus_cmd_e pick_cmd(logic hit, line_st_e cur, logic wr);
    if (!hit && (cur == ST_M)) return CMD_WB;
    else if (wr && hit)        return CMD_UPG;
    else if (wr)               return CMD_RDX;
    else                       return CMD_RD;
  endfunction

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      ra_idx,
  output logic [TAG_W-1:0]      ra_tag,
  output line_st_e              ra_st,
  output logic [DATA_W-1:0]     ra_data,
  input  logic [IDX_W-1:0]      rb_idx,
  output logic [TAG_W-1:0]      rb_tag,
  output line_st_e              rb_st,
  output logic [DATA_W-1:0]     rb_data,
  input  logic                  we,
  input  logic [IDX_W-1:0]      w_idx,
  input  logic [TAG_W-1:0]      w_tag,
  input  line_st_e              w_st,
  input  logic [DATA_W-1:0]     w_data,
  output logic [2*(1<<IDX_W)-1:0] st_flat
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_q [LINES];
  line_st_e          st_q  [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        st_q[i]  <= ST_I;
        dat_q[i] <= '0;
      end
    end else if (we) begin
      tag_q[w_idx] <= w_tag;
      st_q[w_idx]  <= w_st;
      dat_q[w_idx] <= w_data;
    end
  end

  assign ra_tag  = tag_q[ra_idx];
  assign ra_st   = st_q[ra_idx];
  assign ra_data = dat_q[ra_idx];
  assign rb_tag  = tag_q[rb_idx];
  assign rb_st   = st_q[rb_idx];
  assign rb_data = dat_q[rb_idx];

  for (genvar g = 0; g < LINES; g++) begin : g_flat
    assign st_flat[2*g +: 2] = st_q[g];
  end

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              snp_valid,
  input  bus_cmd_e          snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  logic [TAG_W-1:0]  line_tag,
  input  line_st_e          line_st,
  input  logic [DATA_W-1:0] line_data,
  output logic              snp_hit,
  output logic              snp_shared,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data,
  output logic              snp_we,
  output line_st_e          snp_st_nxt
);
  assign snp_hit    = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);
  assign snp_shared = snp_hit && (snp_cmd == CMD_RD);
  assign snp_supply = snp_hit && snoop_supplies(line_st, snp_cmd);
  assign snp_data   = snp_supply ? line_data : '0;
  assign snp_st_nxt = snoop_next(line_st, snp_cmd);
  assign snp_we     = snp_hit && (snp_st_nxt != line_st);
endmodule

// File: rtl/coh_req_unit.sv
module coh_req_unit
  import coh_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic                    cpu_valid,
  input  logic                    cpu_write,
  input  logic [TAG_W+IDX_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  input  logic [TAG_W-1:0]        line_tag,
  input  line_st_e                line_st,
  input  logic [DATA_W-1:0]       line_data,
  input  logic                    snp_valid,
  input  logic                    bus_gnt,
  input  logic                    bus_shared_in,
  input  logic [DATA_W-1:0]       bus_rdata,
  output logic                    cpu_ready,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    bus_req,
  output bus_cmd_e                bus_cmd,
  output logic [TAG_W+IDX_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]       bus_wdata,
  output logic                    lk_hit,
  output logic                    req_we,
  output logic [TAG_W-1:0]        req_tag,
  output line_st_e                req_st,
  output logic [DATA_W-1:0]       req_data
);
  logic [TAG_W-1:0] cpu_tag;
  logic [IDX_W-1:0] cpu_idx;
  logic             active, quick, granted;

  assign cpu_tag = cpu_addr[TAG_W+IDX_W-1:IDX_W];
  assign cpu_idx = cpu_addr[IDX_W-1:0];
  assign active  = cpu_valid && !snp_valid;
  assign lk_hit  = (line_st != ST_I) && (line_tag == cpu_tag);
  assign quick   = local_done(lk_hit, line_st, cpu_write);
  assign bus_cmd = pick_cmd(lk_hit, line_st, cpu_write);
  assign bus_req = active && !quick;
  assign granted = bus_req && bus_gnt;

  assign cpu_ready = active && (quick || (bus_gnt && (bus_cmd != CMD_WB)));
  assign cpu_rdata = (!quick && (bus_cmd == CMD_RD)) ? bus_rdata : line_data;
  assign bus_addr  = (bus_cmd == CMD_WB) ? {line_tag, cpu_idx} : cpu_addr;
  assign bus_wdata = (bus_cmd == CMD_WB) ? line_data : '0;

  assign req_we = (active && quick && cpu_write) || granted;

  always_comb begin
    req_tag  = cpu_tag;
    req_st   = ST_M;
    req_data = cpu_wdata;
    if (!quick) begin
      case (bus_cmd)
        CMD_WB: begin
          req_tag  = line_tag;
          req_st   = ST_I;
          req_data = line_data;
        end
        CMD_RD: begin
          req_st   = fill_state(bus_shared_in);
          req_data = bus_rdata;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_valid,
  output logic                    cpu_ready,
  input  logic                    cpu_write,
  input  logic [TAG_W+IDX_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    bus_req,
  output logic [1:0]              bus_cmd,
  output logic [TAG_W+IDX_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]       bus_wdata,
  input  logic                    bus_gnt,
  input  logic                    bus_shared_in,
  input  logic [DATA_W-1:0]       bus_rdata,
  input  logic                    snp_valid,
  input  logic [1:0]              snp_cmd,
  input  logic [TAG_W+IDX_W-1:0]  snp_addr,
  output logic                    snp_shared,
  output logic                    snp_supply,
  output logic [DATA_W-1:0]       snp_data
);
  localparam int LINES = 1 << IDX_W;

  logic [IDX_W-1:0]   cpu_idx, snp_idx, w_idx;
  logic [TAG_W-1:0]   lk_tag, sn_tag, req_tag, w_tag;
  line_st_e           lk_state, sn_state, req_st, snp_st_nxt, w_st;
  logic [DATA_W-1:0]  lk_data, sn_data, req_data, w_data;
  logic               lk_hit, req_we, snp_hit, snp_we, w_en;
  bus_cmd_e           bus_cmd_e_w;
  logic [2*LINES-1:0] state_flat;

  assign cpu_idx = cpu_addr[IDX_W-1:0];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign bus_cmd = bus_cmd_e_w;

  coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(cpu_idx), .ra_tag(lk_tag), .ra_st(lk_state), .ra_data(lk_data),
    .rb_idx(snp_idx), .rb_tag(sn_tag), .rb_st(sn_state), .rb_data(sn_data),
    .we(w_en), .w_idx(w_idx), .w_tag(w_tag), .w_st(w_st), .w_data(w_data),
    .st_flat(state_flat)
  );

  coh_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid(snp_valid), .snp_cmd(bus_cmd_e'(snp_cmd)),
    .snp_tag(snp_addr[TAG_W+IDX_W-1:IDX_W]),
    .line_tag(sn_tag), .line_st(sn_state), .line_data(sn_data),
    .snp_hit(snp_hit), .snp_shared(snp_shared), .snp_supply(snp_supply),
    .snp_data(snp_data), .snp_we(snp_we), .snp_st_nxt(snp_st_nxt)
  );

  coh_req_unit #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_req (
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .line_tag(lk_tag), .line_st(lk_state),
    .line_data(lk_data), .snp_valid(snp_valid), .bus_gnt(bus_gnt),
    .bus_shared_in(bus_shared_in), .bus_rdata(bus_rdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .bus_req(bus_req),
    .bus_cmd(bus_cmd_e_w), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .lk_hit(lk_hit), .req_we(req_we), .req_tag(req_tag), .req_st(req_st),
    .req_data(req_data)
  );

  // snoop owns the single write port whenever it is active; the request
  // side is idle in that cycle, so the two never collide
  always_comb begin
    if (snp_we) begin
      w_en   = 1'b1;
      w_idx  = snp_idx;
      w_tag  = sn_tag;
      w_st   = snp_st_nxt;
      w_data = sn_data;
    end else begin
      w_en   = req_we;
      w_idx  = cpu_idx;
      w_tag  = req_tag;
      w_st   = req_st;
      w_data = req_data;
    end
  end

endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk
  import coh_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cpu_valid,
  input logic                      cpu_ready,
  input logic                      cpu_write,
  input logic [IDX_W-1:0]          cpu_idx,
  input logic                      bus_req,
  input logic                      bus_gnt,
  input logic [1:0]                bus_cmd,
  input logic                      bus_shared_in,
  input logic                      snp_valid,
  input logic [IDX_W-1:0]          snp_idx,
  input logic                      snp_supply,
  input logic                      lk_hit,
  input logic [1:0]                lk_state,
  input logic [2*(1<<IDX_W)-1:0]   state_flat
);
  logic [IDX_W-1:0] cpu_idx_q, snp_idx_q;
  logic [1:0]       st_cpu_prev, st_snp_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_idx_q <= '0;
      snp_idx_q <= '0;
    end else begin
      cpu_idx_q <= cpu_idx;
      snp_idx_q <= snp_idx;
    end
  end

  assign st_cpu_prev = state_flat[{cpu_idx_q, 1'b0} +: 2];
  assign st_snp_prev = state_flat[{snp_idx_q, 1'b0} +: 2];

  AST_E_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_write && !snp_valid && lk_hit && lk_state == 2'b10)
      |-> (cpu_ready && !bus_req)); // R2

  AST_WRITE_LEAVES_M: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && cpu_write) |=> (st_cpu_prev == 2'b11)); // R6

  AST_FILL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == 2'b00)
      |=> (st_cpu_prev == ($past(bus_shared_in) ? 2'b01 : 2'b10))); // R5

  AST_SUPPLY_LEAVES_M: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |=> (st_snp_prev != 2'b11)); // R3

  AST_SNOOP_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> (!cpu_ready && !bus_req)); // R9

  AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_gnt |-> bus_req); // R9

  AST_WB_HOLDS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == 2'b11) |-> !cpu_ready); // R8

endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
  .cpu_write(cpu_write), .cpu_idx(cpu_idx), .bus_req(bus_req),
  .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_shared_in(bus_shared_in),
  .snp_valid(snp_valid), .snp_idx(snp_idx), .snp_supply(snp_supply),
  .lk_hit(lk_hit), .lk_state(lk_state), .state_flat(state_flat)
);

// File: tb/coh_line_ctrl_test.sv
module coh_line_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [5:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic       cpu_ready;
  logic [7:0] cpu_rdata;
  logic       bus_req;
  logic [1:0] bus_cmd;
  logic [5:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_gnt = 1'b0, bus_shared_in = 1'b0;
  logic [7:0] bus_rdata = '0;
  logic       snp_valid = 1'b0;
  logic [1:0] snp_cmd = '0;
  logic [5:0] snp_addr = '0;
  logic       snp_shared, snp_supply;
  logic [7:0] snp_data;

  int n_chk = 0, n_bad = 0;

  // bench model: states I=0 S=1 E=2 M=3, commands RD=0 RDX=1 UPG=2 WB=3
  logic [1:0] m_st  [4];
  logic [3:0] m_tag [4];
  logic [7:0] m_dat [4];
  logic [7:0] mem   [64];

  coh_line_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_write(cpu_write), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_gnt(bus_gnt),
    .bus_shared_in(bus_shared_in), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_supply(snp_supply), .snp_data(snp_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_hit(logic [5:0] a);
    return (m_st[a[1:0]] != 2'd0) && (m_tag[a[1:0]] == a[5:2]);
  endfunction

  // command the rules call for when a request cannot finish locally
  function automatic logic [1:0] want_cmd(logic [5:0] a, logic wr);
    if (!m_hit(a) && m_st[a[1:0]] == 2'd3) return 2'd3;
    if (wr && m_hit(a))                    return 2'd2;
    if (wr)                                return 2'd1;
    return 2'd0;
  endfunction

  function automatic string cmd_req(logic [1:0] c);
    case (c)
      2'd0: return "R5";
      2'd1: return "R6";
      2'd2: return "R4";
      default: return "R8";
    endcase
  endfunction

  // starts and ends at a falling edge
  task automatic cpu_op(input logic wr, input logic [5:0] a, input logic [7:0] wd);
    bit done = 0;
    logic [1:0] i = a[1:0];
    cpu_valid = 1; cpu_write = wr; cpu_addr = a; cpu_wdata = wd;
    for (int step = 0; step < 4 && !done; step++) begin
      #1;
      if (m_hit(a) && (!wr || m_st[i] >= 2'd2)) begin
        chk(bus_req == 0, wr ? "R2" : "R10", 32'(bus_req), 0);
        chk(cpu_ready == 1, wr ? "R2" : "R10", 32'(cpu_ready), 1);
        if (!wr) chk(cpu_rdata == m_dat[i], "R10", 32'(cpu_rdata), 32'(m_dat[i]));
        else begin m_st[i] = 2'd3; m_dat[i] = wd; end
        done = 1;
      end else begin
        logic [1:0] c = want_cmd(a, wr);
        logic [5:0] ea = (c == 2'd3) ? {m_tag[i], i} : a;
        chk(bus_req == 1, cmd_req(c), 32'(bus_req), 1);
        chk(bus_cmd == c, cmd_req(c), 32'(bus_cmd), 32'(c));
        chk(bus_addr == ea, cmd_req(c), 32'(bus_addr), 32'(ea));
        if (c == 2'd3) chk(bus_wdata == m_dat[i], "R8", 32'(bus_wdata), 32'(m_dat[i]));
        bus_gnt = 1; bus_shared_in = 1'($urandom % 2); bus_rdata = mem[a];
        #1;
        chk(cpu_ready == (c != 2'd3), "R9", 32'(cpu_ready), 32'(c != 2'd3));
        case (c)
          2'd3: begin mem[ea] = m_dat[i]; m_st[i] = 2'd0; end
          2'd0: begin
            chk(cpu_rdata == mem[a], "R5", 32'(cpu_rdata), 32'(mem[a]));
            m_st[i] = bus_shared_in ? 2'd1 : 2'd2; m_tag[i] = a[5:2]; m_dat[i] = mem[a];
          end
          default: begin m_st[i] = 2'd3; m_tag[i] = a[5:2]; m_dat[i] = wd; end
        endcase
        done = (c != 2'd3);
      end
      @(posedge clk);
      @(negedge clk);
      bus_gnt = 0; bus_shared_in = 0;
    end
    cpu_valid = 0; cpu_write = 0;
  endtask

  task automatic snoop_op(input logic [1:0] c, input logic [5:0] a, input bit hold_cpu);
    logic [1:0] i = a[1:0];
    bit hit = m_hit(a);
    bit sup = hit && m_st[i] == 2'd3 && (c == 2'd0 || c == 2'd1);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    if (hold_cpu) begin cpu_valid = 1; cpu_write = 0; cpu_addr = a ^ 6'h04; end
    #1;
    if (hold_cpu) begin
      chk(cpu_ready == 0, "R9", 32'(cpu_ready), 0);
      chk(bus_req == 0, "R9", 32'(bus_req), 0);
    end
    chk(snp_shared == (hit && c == 2'd0), "R7", 32'(snp_shared), 32'(hit && c == 2'd0));
    chk(snp_supply == sup, "R3", 32'(snp_supply), 32'(sup));
    if (sup) begin
      chk(snp_data == m_dat[i], "R3", 32'(snp_data), 32'(m_dat[i]));
      mem[a] = m_dat[i];
    end
    if (hit) begin
      if (c == 2'd0) m_st[i] = 2'd1;
      else if (c != 2'd3) m_st[i] = 2'd0;
    end
    @(posedge clk);
    @(negedge clk);
    snp_valid = 0; cpu_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int k = 0; k < 4; k++) begin m_st[k] = 0; m_tag[k] = 0; m_dat[k] = 0; end
    for (int k = 0; k < 64; k++) mem[k] = 8'(k * 37 + 11);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: nothing is held after reset
    chk(bus_req == 0 && cpu_ready == 0, "R1", 32'({bus_req, cpu_ready}), 0);
    for (int k = 0; k < 4; k++) begin
      snp_valid = 1; snp_cmd = 2'd0; snp_addr = 6'(k);
      #1;
      chk(snp_shared == 0 && snp_supply == 0, "R1", 32'({snp_shared, snp_supply}), 0);
    end
    snp_valid = 0;
    cpu_valid = 1; cpu_addr = 6'h05; #1;
    chk(bus_req == 1 && bus_cmd == 2'd0, "R1", 32'({bus_req, bus_cmd}), 32'h4);
    cpu_valid = 0;

    // directed sequence
    cpu_op(0, 6'h05, 0);          // fill (R5)
    cpu_op(1, 6'h05, 8'hA1);      // silent upgrade if E (R2), else invalidate
    cpu_op(0, 6'h05, 0);          // hit (R10)
    snoop_op(2'd0, 6'h05, 0);     // supply, go S (R3)
    cpu_op(1, 6'h05, 8'hB2);      // upgrade from S (R4)
    snoop_op(2'd1, 6'h05, 0);     // supply, go I (R3)
    cpu_op(0, 6'h09, 0);
    snoop_op(2'd0, 6'h09, 0);     // R7
    snoop_op(2'd2, 6'h09, 0);     // R4 invalidate of S
    cpu_op(1, 6'h0A, 8'hC3);      // store miss (R6)
    cpu_op(0, 6'h0E, 0);          // dirty victim writeback then fill (R8)
    cpu_op(0, 6'h12, 0);          // clean victim replaced silently (R8)
    snoop_op(2'd0, 6'h20, 1);     // local side stalls (R9)
    snoop_op(2'd0, 6'h31, 0);     // miss leaves state alone (R7)
    cpu_op(0, 6'h12, 0);

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      logic [5:0] a = {2'b00, 2'($urandom % 4), 2'($urandom % 4)};
      if ($urandom % 2 == 0) begin
        cpu_op(1'($urandom % 2), a, 8'($urandom));
      end else begin
        logic [1:0] c = 2'($urandom % 4);
        if (c == 2'd2 && m_hit(a) && m_st[a[1:0]] >= 2'd2) c = 2'd1;
        snoop_op(c, a, ($urandom % 8) == 0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule